// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block receives a 20-bit configuration word over a write-only three-wire link made of a serial clock, a serial data line and a strobe. The strobe rests high. A host pulls it low to open a write and then presents the bits with the most significant bit first, one bit for each rising serial clock edge. When the strobe returns high, the word collected in the shift register is copied into a holding register. The decoded control fields come from the holding register alone, so a write that is still in progress never disturbs the fields in use.

All three serial lines are brought into the system clock domain through multi-flop synchronizers, and every edge is found in that domain. A reset or an asserted undervoltage flag forces the held word, and with it every field, to zero. The zero word means sleep, because the top bit must be high for normal operation. A frame does not have to be exactly 20 bits long. Whatever the shift register holds when the strobe rises is the word that gets latched.

Top module: `cfg_serial_port`

## Requirements
- R1: A frame of 20 bits sent most significant bit first lands in the held word so that the first bit sent occupies bit 19 and the last occupies bit 0.
- R2: Data is shifted in only on a rising serial clock edge while the strobe is low; serial clock pulses while the strobe is high leave the shift register unchanged.
- R3: The shift register is copied into the held word on the strobe's rising edge, and the held word keeps its previous value for the whole time the strobe is low.
- R4: After reset the held word is zero and the sleep output is high.
- R5: While the undervoltage input is high the held word and the shift register are cleared, and the held word reads zero one system clock later.
- R6: The decoded outputs take these bits of the held word: blankSel 1:0, offTime 6:2, fastDecay 10:7, rectPassive 11, rectEnable 12, extChopSlow 13, enablePol 14, phasePol 15, rangePol 16, intDecayPol 17, testMode 18.
- R7: The shift register is not cleared when a frame starts. A frame of N bits other than 20 latches the previous contents shifted left by N, with the new bits in the low positions, and a frame with no clock edges latches the previous contents unchanged.
- R8: sleepActive is high exactly when bit 19 of the held word is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| uvFault | input | 1 | Undervoltage flag, high clears the configuration |
| serClk | input | 1 | Serial clock; data is taken on its rising edge |
| serData | input | 1 | Serial data, most significant bit first |
| serStrobe | input | 1 | Write frame strobe, idles high, low during a write |
| heldWord | output | 20 | Latched configuration word |
| blankSel | output | 2 | Blanking interval select |
| offTime | output | 5 | Fixed off-time code |
| fastDecay | output | 4 | Fast-decay portion code |
| rectPassive | output | 1 | Rectification mode, high for passive |
| rectEnable | output | 1 | Synchronous rectification enable |
| extChopSlow | output | 1 | Decay used for external chopping, high for slow |
| enablePol | output | 1 | Enable input polarity bit |
| phasePol | output | 1 | Phase input polarity bit |
| rangePol | output | 1 | Range input polarity bit |
| intDecayPol | output | 1 | Internal decay mode polarity bit |
| testMode | output | 1 | Test bit |
| sleepActive | output | 1 | High when the sleep state is selected |

## Verification
The bench builds the block with its defaults: a 20-bit word and two synchronizer stages. It holds each serial line level for three system clocks, so every edge clears the synchronizer before the next one arrives. Under these values, full-length frames, short frames, overlong frames, clock-free frames and clock pulses outside a frame all come within reach, and each one is compared against a bench model of the shift register. The undervoltage clear and the sleep decode of the zero word are checked after random frames have left non-zero contents behind.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int CFG_WORD_W = 20;

  typedef struct packed {
    logic shiftEn;
    logic latchEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[b] <= {STAGES{RESET_VAL[b]}};
      else        chain[b] <= {chain[b][STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_port_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         serClkS,
  input  logic         strobeS,
  output ctrlStrobes_t strobes
);
  logic clkPrev;
  logic strobePrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkPrev    <= 1'b0;
      strobePrev <= 1'b1;
    end else begin
      clkPrev    <= serClkS;
      strobePrev <= strobeS;
    end
  end

  always_comb begin
    strobes.shiftEn = serClkS && !clkPrev && !strobeS;
    strobes.latchEn = strobeS && !strobePrev;
  end

  // R3: a latch follows a low strobe in the previous cycle
  a_r3_latch_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.latchEn |-> !$past(strobeS));
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import cfg_port_pkg::*;
#(
  parameter int WORD_W = CFG_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clearCfg,
  input  logic              dataS,
  input  ctrlStrobes_t      strobes,
  output logic [WORD_W-1:0] heldWord
);
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      heldWord <= '0;
    end else if (clearCfg) begin
      shiftReg <= '0;
      heldWord <= '0;
    end else begin
      if (strobes.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], dataS};
      if (strobes.latchEn) heldWord <= shiftReg;
    end
  end

  // R5: undervoltage leaves the held word at zero
  a_r5_uv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clearCfg |=> heldWord == '0);

  // R3: held word only moves on a latch or a clear
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.latchEn && !clearCfg) |=> $stable(heldWord));

  // R2: shift register only moves on a shift or a clear
  a_r2_shift_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.shiftEn && !clearCfg) |=> $stable(shiftReg));

  // R1: each shift moves the word up one place and takes the new bit at bit 0
  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.shiftEn && !clearCfg) |=>
      (shiftReg == {$past(shiftReg[WORD_W-2:0]), $past(dataS)}));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  uvFault,
  input  logic                  serClk,
  input  logic                  serData,
  input  logic                  serStrobe,
  output logic [CFG_WORD_W-1:0] heldWord,
  output logic [1:0]            blankSel,
  output logic [4:0]            offTime,
  output logic [3:0]            fastDecay,
  output logic                  rectPassive,
  output logic                  rectEnable,
  output logic                  extChopSlow,
  output logic                  enablePol,
  output logic                  phasePol,
  output logic                  rangePol,
  output logic                  intDecayPol,
  output logic                  testMode,
  output logic                  sleepActive
);
  logic [2:0]   syncLines;
  ctrlStrobes_t strobes;

  // bit 2 strobe (idles high), bit 1 data, bit 0 serial clock
  cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({serStrobe, serData, serClk}),
    .syncOut (syncLines)
  );

  cfg_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .serClkS (syncLines[0]),
    .strobeS (syncLines[2]),
    .strobes (strobes)
  );

  cfg_datapath #(.WORD_W(CFG_WORD_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clearCfg (uvFault),
    .dataS    (syncLines[1]),
    .strobes  (strobes),
    .heldWord (heldWord)
  );

  always_comb begin
    blankSel    = heldWord[1:0];
    offTime     = heldWord[6:2];
    fastDecay   = heldWord[10:7];
    rectPassive = heldWord[11];
    rectEnable  = heldWord[12];
    extChopSlow = heldWord[13];
    enablePol   = heldWord[14];
    phasePol    = heldWord[15];
    rangePol    = heldWord[16];
    intDecayPol = heldWord[17];
    testMode    = heldWord[18];
    sleepActive = !heldWord[19];
  end

  // R8: after an undervoltage cycle the port reports sleep
  a_r8_uv_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    uvFault |=> sleepActive);
endmodule

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvFault = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serStrobe = 1'b1;
  logic [19:0] heldWord;
  logic [1:0] blankSel;
  logic [4:0] offTime;
  logic [3:0] fastDecay;
  logic rectPassive, rectEnable, extChopSlow, enablePol, phasePol;
  logic rangePol, intDecayPol, testMode, sleepActive;

  int checks = 0;
  int errors = 0;
  logic [19:0] modelShift = '0;
  logic [19:0] modelHeld = '0;

  always #4 clk = ~clk;

  cfg_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .uvFault(uvFault),
    .serClk(serClk), .serData(serData), .serStrobe(serStrobe),
    .heldWord(heldWord), .blankSel(blankSel), .offTime(offTime),
    .fastDecay(fastDecay), .rectPassive(rectPassive), .rectEnable(rectEnable),
    .extChopSlow(extChopSlow), .enablePol(enablePol), .phasePol(phasePol),
    .rangePol(rangePol), .intDecayPol(intDecayPol), .testMode(testMode),
    .sleepActive(sleepActive)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkFields(input string req);
    check(req, 32'(heldWord), 32'(modelHeld));
    check({req, " R6 blankSel"}, 32'(blankSel), 32'(modelHeld[1:0]));
    check({req, " R6 offTime"}, 32'(offTime), 32'(modelHeld[6:2]));
    check({req, " R6 fastDecay"}, 32'(fastDecay), 32'(modelHeld[10:7]));
    check({req, " R6 flags"},
          32'({testMode, intDecayPol, rangePol, phasePol, enablePol,
               extChopSlow, rectEnable, rectPassive}),
          32'(modelHeld[18:11]));
    check({req, " R8 sleep"}, 32'(sleepActive), 32'(!modelHeld[19]));
  endtask

  task automatic pulseClk(input logic bitVal);
    serData = bitVal;
    waitClk(3);
    serClk = 1'b1;
    waitClk(3);
    serClk = 1'b0;
    waitClk(3);
  endtask

  // sends the low n bits of value, most significant of them first
  task automatic sendFrame(input logic [31:0] value, input int n, input string req);
    serStrobe = 1'b0;
    waitClk(3);
    for (int i = n - 1; i >= 0; i--) begin
      pulseClk(value[i]);
      modelShift = {modelShift[18:0], value[i]};
    end
    check({req, " R3 held during frame"}, 32'(heldWord), 32'(modelHeld));
    serStrobe = 1'b1;
    waitClk(6);
    modelHeld = modelShift;
    checkFields(req);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    waitClk(3);
    rst_n = 1'b1;
    waitClk(3);
    // R4 reset state
    checkFields("R4 reset");
    check("R4 sleep after reset", 32'(sleepActive), 32'd1);

    // R1 directed full frames
    sendFrame(32'h80001, 20, "R1 ends");
    check("R1 msb first", 32'(heldWord[19]), 32'd1);
    sendFrame(32'h5A5A5, 20, "R1 pattern");
    sendFrame(32'h7FFFF, 20, "R8 all fields high sleep");

    // R2 clock pulses with strobe high are ignored; R7 empty frame keeps contents
    pulseClk(1'b0);
    pulseClk(1'b1);
    pulseClk(1'b0);
    check("R2 no change outside frame", 32'(heldWord), 32'(modelHeld));
    sendFrame(32'h0, 0, "R2 R7 empty frame");

    // R7 short and long frames
    sendFrame(32'h5, 3, "R7 short frame");
    sendFrame(32'h3ABCDE, 24, "R7 long frame");

    // random frames
    for (int k = 0; k < 20; k++) begin
      logic [31:0] v;
      int len;
      v = $urandom;
      len = ($urandom % 4 == 0) ? int'($urandom % 26) : 20;
      sendFrame(v, len, "R1 R6 R7 random");
    end

    // R5 undervoltage clear
    sendFrame(32'hFFFFF, 20, "R5 preload");
    uvFault = 1'b1;
    waitClk(2);
    modelShift = '0;
    modelHeld = '0;
    check("R5 held cleared during uv", 32'(heldWord), 32'd0);
    uvFault = 1'b0;
    waitClk(1);
    checkFields("R5 after uv");
    sendFrame(32'h0, 0, "R5 shift register cleared");
    sendFrame(32'hC0F0F, 20, "R1 after uv");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule